// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical address. It keeps four 16-bit segment base registers: code, data, stack and extra. To form an address it shifts the selected base left by four bits and adds a 16-bit offset. Any carry out of the top bit is dropped, so every address wraps inside a 1 MB space, and each segment covers a 64 KB window.

The offset registers are outside this block. The instruction pointer, source index, destination index, stack pointer or base pointer reaches it as a plain offset value, together with the kind of access. The kind of access sets the default segment. An override input can replace that default with any segment named explicitly.

The segment registers are written through a simple write port. The result is registered and comes with a valid flag. At reset the code segment loads FFFFh. The output register loads the first fetch location, FFFF0h, which is the code segment paired with an instruction pointer of zero.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, the code segment holds FFFFh, the data, stack and extra segments hold 0000h, `phys_addr` reads FFFF0h and `phys_valid` is 0. A fetch with offset 0000h issued first after reset yields FFFF0h.
- R2: A request accepted at a clock edge makes `phys_addr` equal (segment × 16 + offset) mod 2^20 after that same edge. For example, segment A4FBh with offset 4872h gives A9822h.
- R3: The carry out of bit 19 is discarded. Segment FFFFh with offset 0010h gives 00000h, and with offset FFFFh it gives 0FFEFh.
- R4: With `ovr_en` low, `acc_kind` picks the segment as follows: 0 = fetch uses code, 1 = data uses data, 2 = stack uses stack, 3 = string destination uses extra.
- R5: With `ovr_en` high, `ovr_seg` picks the segment whatever the access kind is. The codes are 0 = code, 1 = data, 2 = stack, 3 = extra.
- R6: A segment write with `seg_wr_en` high takes effect at the next clock edge. A request made in the same cycle as the write uses the old value, and a request in the following cycle uses the new value.
- R7: `phys_valid` is the value of `req_valid` one cycle earlier. When no request is made, `phys_addr` keeps its previous value.
- R8: A write changes only the segment named by `seg_wr_sel` (same codes as R5). The other three segments are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Write strobe for a segment register |
| seg_wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment base value |
| req_valid | input | 1 | Address request this cycle |
| acc_kind | input | 2 | Access kind (0 fetch, 1 data, 2 stack, 3 string destination) |
| offset | input | 16 | Offset from the matching pointer or index register |
| ovr_en | input | 1 | Use `ovr_seg` in place of the default segment |
| ovr_seg | input | 2 | Explicit segment choice |
| phys_addr | output | 20 | Registered physical address |
| phys_valid | output | 1 | `phys_addr` holds the result of the last cycle's request |

## Verification
Every address is due exactly one clock edge after the cycle in which its request is presented. A segment write is visible to requests made from the following cycle on. The bench drives each input set on the falling edge and samples `phys_addr` and `phys_valid` one time unit after the next rising edge. It works out the expected address from its own copy of the segment registers as they stood before that edge, and only then applies the cycle's write to that copy. This order is what shows the old-value rule of R6 and the hold rule of R7.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_t;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_DATA   = 2'd1,
    ACC_STACK  = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_t;

  // Default segment for each kind of access
  function automatic seg_id_t default_seg(input acc_kind_t kind);
    case (kind)
      ACC_FETCH:  default_seg = SEG_CODE;
      ACC_DATA:   default_seg = SEG_DATA;
      ACC_STACK:  default_seg = SEG_STACK;
      default:    default_seg = SEG_EXTRA;
    endcase
  endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int NUM_SEG = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  localparam int SEL_W = $clog2(NUM_SEG)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [SEG_W-1:0]                wr_data,
  input  logic [SEL_W-1:0]                rd_sel,
  output logic [SEG_W-1:0]                rd_value,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   bank
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (g == int'(SEG_CODE)) ? CODE_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[g] <= RST_VAL;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        bank[g] <= wr_data;
    end
  end

  // Read of the current contents: a write in this cycle is not yet visible
  assign rd_value = bank[rd_sel];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       ovr_en,
  input  logic [1:0] ovr_seg,
  output logic [1:0] sel_seg
);

  always_comb begin
    if (ovr_en)
      sel_seg = ovr_seg;
    else
      sel_seg = default_seg(acc_kind_t'(acc_kind));
  end

endmodule

// File: rtl/addr_sum.sv
module addr_sum #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W = 20,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  parameter logic [OFF_W-1:0] IP_RST = '0,
  localparam int SHIFT = PA_W - SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] seg_value,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  sum_next,
  output logic [PA_W-1:0]  phys_addr,
  output logic             phys_valid
);

  // Shifted base plus offset, truncated to PA_W bits (carry dropped)
  function automatic logic [PA_W-1:0] form_pa(input logic [SEG_W-1:0] seg,
                                              input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] base;
    base = {seg, {SHIFT{1'b0}}};
    form_pa = base + PA_W'(off);
  endfunction

  localparam logic [PA_W-1:0] BOOT_PA = form_pa(CODE_RST, IP_RST);

  assign sum_next = form_pa(seg_value, offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= BOOT_PA;
      phys_valid <= 1'b0;
    end else begin
      phys_valid <= req_valid;
      if (req_valid)
        phys_addr <= sum_next;
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W = 20,
  parameter int NUM_SEG = 4,
  parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF,
  parameter logic [OFF_W-1:0] IP_RST = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             req_valid,
  input  logic [1:0]       acc_kind,
  input  logic [OFF_W-1:0] offset,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  output logic [PA_W-1:0]  phys_addr,
  output logic             phys_valid
);

  logic [1:0]                        sel_seg;
  logic [SEG_W-1:0]                  seg_value;
  logic [NUM_SEG-1:0][SEG_W-1:0]     seg_regs;
  logic [PA_W-1:0]                   sum_next;

  seg_pick u_pick (
    .acc_kind (acc_kind),
    .ovr_en   (ovr_en),
    .ovr_seg  (ovr_seg),
    .sel_seg  (sel_seg)
  );

  seg_bank #(
    .SEG_W    (SEG_W),
    .NUM_SEG  (NUM_SEG),
    .CODE_RST (CODE_RST)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (seg_wr_en),
    .wr_sel   (seg_wr_sel),
    .wr_data  (seg_wr_data),
    .rd_sel   (sel_seg),
    .rd_value (seg_value),
    .bank     (seg_regs)
  );

  addr_sum #(
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .PA_W     (PA_W),
    .CODE_RST (CODE_RST),
    .IP_RST   (IP_RST)
  ) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .seg_value  (seg_value),
    .offset     (offset),
    .sum_next   (sum_next),
    .phys_addr  (phys_addr),
    .phys_valid (phys_valid)
  );

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W = 20,
  parameter int NUM_SEG = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          seg_wr_en,
  input logic [1:0]                    seg_wr_sel,
  input logic [SEG_W-1:0]              seg_wr_data,
  input logic                          req_valid,
  input logic [1:0]                    acc_kind,
  input logic [OFF_W-1:0]              offset,
  input logic                          ovr_en,
  input logic [1:0]                    ovr_seg,
  input logic [1:0]                    sel_seg,
  input logic [SEG_W-1:0]              seg_value,
  input logic [NUM_SEG-1:0][SEG_W-1:0] seg_regs,
  input logic [PA_W-1:0]               phys_addr,
  input logic                          phys_valid
);

  p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> phys_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!phys_valid && $stable(phys_addr)));

  p_addr_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> phys_addr ==
      PA_W'({$past(seg_value), 4'h0}) + PA_W'($past(offset)));

  p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && acc_kind == 2'd0) |-> sel_seg == 2'd0);

  p_strdst_extra_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && acc_kind == 2'd3) |-> sel_seg == 2'd3);

  p_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> sel_seg == ovr_seg);

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> seg_regs[$past(seg_wr_sel)] == $past(seg_wr_data));

  p_no_write_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_wr_en |=> $stable(seg_regs));

endmodule

bind seg_addr_gen seg_addr_chk #(
  .SEG_W   (SEG_W),
  .OFF_W   (OFF_W),
  .PA_W    (PA_W),
  .NUM_SEG (NUM_SEG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seg_wr_en   (seg_wr_en),
  .seg_wr_sel  (seg_wr_sel),
  .seg_wr_data (seg_wr_data),
  .req_valid   (req_valid),
  .acc_kind    (acc_kind),
  .offset      (offset),
  .ovr_en      (ovr_en),
  .ovr_seg     (ovr_seg),
  .sel_seg     (sel_seg),
  .seg_value   (seg_value),
  .seg_regs    (seg_regs),
  .phys_addr   (phys_addr),
  .phys_valid  (phys_valid)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [15:0] offset = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [19:0] phys_addr;
  logic        phys_valid;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] model_seg [4];
  logic [19:0] last_pa;

  always #4 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .acc_kind(acc_kind), .offset(offset),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .phys_addr(phys_addr), .phys_valid(phys_valid)
  );

  function automatic logic [19:0] exp_pa(input logic [15:0] s, input logic [15:0] o);
    longint v;
    v = longint'(s) * 16 + longint'(o);
    return 20'(v % 1048576);
  endfunction

  function automatic int pick(input logic [1:0] kind, input logic oe, input logic [1:0] os);
    if (oe) return int'(os);
    case (kind)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                       input logic rv, input logic [1:0] kind, input logic [15:0] off,
                       input logic oe, input logic [1:0] os, input string req);
    logic [19:0] e;
    @(negedge clk);
    seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
    req_valid = rv; acc_kind = kind; offset = off; ovr_en = oe; ovr_seg = os;
    e = rv ? exp_pa(model_seg[pick(kind, oe, os)], off) : last_pa;
    @(posedge clk);
    #1;
    check({req, " valid"}, 32'(phys_valid), 32'(rv));
    check({req, " addr"}, 32'(phys_addr), 32'(e));
    last_pa = e;
    if (we) model_seg[ws] = wd;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cycles, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_seg[0] = 16'hFFFF; model_seg[1] = 0; model_seg[2] = 0; model_seg[3] = 0;
    last_pa = 20'hFFFF0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values seen at the outputs
    check("R1 reset addr", 32'(phys_addr), 32'h000FFFF0);
    check("R1 reset valid", 32'(phys_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first fetch with offset zero
    cycle(0, 0, 0, 1, 2'd0, 16'h0000, 0, 0, "R1 boot fetch");
    // R1: other segments zero after reset
    cycle(0, 0, 0, 1, 2'd1, 16'h0123, 0, 0, "R1 data seg zero");
    cycle(0, 0, 0, 1, 2'd3, 16'h0456, 0, 0, "R1 extra seg zero");
    // R2: worked example
    cycle(1, 2'd1, 16'hA4FB, 0, 0, 0, 0, 0, "R7 idle during write");
    cycle(0, 0, 0, 1, 2'd1, 16'h4872, 0, 0, "R2 example A9822");
    check("R2 example literal", 32'(phys_addr), 32'h000A9822);
    // R3: wrap at 20 bits
    cycle(0, 0, 0, 1, 2'd0, 16'h0010, 0, 0, "R3 wrap to zero");
    check("R3 wrap literal", 32'(phys_addr), 32'h0);
    cycle(0, 0, 0, 1, 2'd0, 16'hFFFF, 0, 0, "R3 wrap FFFF");
    check("R3 wrap literal2", 32'(phys_addr), 32'h0FFEF);
    // R4: distinct segment values then each default
    cycle(1, 2'd0, 16'h1000, 0, 0, 0, 0, 0, "R7 idle");
    cycle(1, 2'd2, 16'h3000, 0, 0, 0, 0, 0, "R7 idle");
    cycle(1, 2'd3, 16'h4000, 0, 0, 0, 0, 0, "R7 idle");
    for (int k = 0; k < 4; k++)
      cycle(0, 0, 0, 1, 2'(k), 16'h0042, 0, 0, "R4 default segment");
    // R5: override against each kind
    for (int k = 0; k < 4; k++)
      cycle(0, 0, 0, 1, 2'(k), 16'h0007, 1, 2'(3 - k), "R5 override");
    // R6: same-cycle write uses old value, next cycle uses new
    cycle(1, 2'd1, 16'h1234, 1, 2'd1, 16'h0001, 0, 0, "R6 old value");
    check("R6 old literal", 32'(phys_addr), 32'h0A4FB1);
    cycle(0, 0, 0, 1, 2'd1, 16'h0001, 0, 0, "R6 new value");
    check("R6 new literal", 32'(phys_addr), 32'h012341);
    // R7: idle cycles hold the address
    cycle(0, 0, 0, 0, 2'd2, 16'hBEEF, 1, 2'd2, "R7 hold");
    cycle(0, 0, 0, 0, 2'd0, 16'h0000, 0, 0, "R7 hold again");
    // R8: write to extra leaves the others
    cycle(1, 2'd3, 16'hCAFE, 0, 0, 0, 0, 0, "R8 write extra");
    for (int k = 0; k < 3; k++)
      cycle(0, 0, 0, 1, 2'd0, 16'h0100, 1, 2'(k), "R8 others unchanged");
    // Random mix: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] & r[1], r[3:2], 16'($urandom), r[4] | r[5], r[7:6], 16'($urandom),
            r[8] & r[9], r[11:10], "R2 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule